// File: doc/BRIEF.md
# Privilege-Masked Authority Mask Register Block

This block holds three 64-bit special-purpose registers. The first is an authority mask that the processor uses to guard storage accesses. The second is a user override mask that sets which authority bits unprivileged code may change. The third is a supervisor override mask that sets which bits an ordinary supervisor may change. Software reaches all three through one register port. The port carries an address, write data, a write enable, a read enable and two privilege bits: a user-state bit and a hypervisor-state bit.

A write is a masked bit insertion, not a plain store. The bits selected by the governing mask take the new data and every other bit keeps its old value. Which mask governs depends on the current privilege. Hypervisor writes are unmasked. The authority mask appears at two register numbers that share one storage element. Number 13 is open to user code and number 29 is privileged. When an access is not allowed, the block raises a combinational error in the same cycle, changes nothing, and reads back zero.

Top module: `auth_mask_block`

## Requirements
- R1: After synchronous reset all three registers read as zero.
- R2: A user-state write (user bit 1) to number 13 updates the authority mask to (old AND NOT user_mask) OR (data AND user_mask).
- R3: A supervisor-state write (user 0, hyp 0) to number 13 or 29 updates the authority mask under the same insertion rule, with the supervisor mask in place of the user mask.
- R4: A hypervisor-state write (user 0, hyp 1) to number 13 or 29 stores the whole data word into the authority mask.
- R5: The user override mask sits at number 40. A supervisor write to it inserts data under the supervisor mask. A hypervisor write stores the whole word.
- R6: Numbers 13 and 29 return the same stored authority value, and a write through either one updates that single register.
- R7: From user state, any read or write to number 29 or number 40 raises access_err. Such a write changes nothing and such a read returns zero.
- R8: The supervisor override mask sits at number 41 and can be read or written only in hypervisor state. Any other access raises access_err, leaves all registers unchanged and reads back zero.
- R9: Any access to an unmapped number raises access_err and has no effect.
- R10: A permitted read returns the current stored value combinationally, in the same cycle. A write becomes visible after the next rising clock edge. access_err is high only in a cycle that holds an illegal access.
- R11: When the user and hypervisor bits are both 1, the access is treated as user state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Register number of the access |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| wdata | input | 64 | Write data |
| priv_user | input | 1 | Current context is user state |
| priv_hyp | input | 1 | Current context is hypervisor state |
| rdata | output | 64 | Read data, zero unless a permitted read |
| access_err | output | 1 | Illegal access in this cycle |

## Verification
The hardest case to reach is a masked insertion where the governing mask and the old register value are both non-trivial and different. Only then does a wrong mask choice, or a plain store, show up at the read port. To get there, the stimulus first uses hypervisor writes to load the two override masks with different, interleaved bit patterns. It then issues user and supervisor writes of all-ones and all-zeros data, and finally a long run of random contexts, addresses and data. A behavioural model in the bench predicts rdata and access_err on every cycle.

// File: rtl/auth_mask_pkg.sv
package auth_mask_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned ADDR_W = 10;

    // Register numbers. The two authority aliases matter to software.
    localparam logic [ADDR_W-1:0] NUM_AUTH_USR = ADDR_W'(13);
    localparam logic [ADDR_W-1:0] NUM_AUTH_PRV = ADDR_W'(29);
    localparam logic [ADDR_W-1:0] NUM_UOVR     = ADDR_W'(40);
    localparam logic [ADDR_W-1:0] NUM_SOVR     = ADDR_W'(41);

    typedef enum logic [1:0] {
        CTX_USER = 2'd0,
        CTX_SUP  = 2'd1,
        CTX_HYP  = 2'd2
    } ctx_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_AUTH = 2'd1,
        TGT_UOVR = 2'd2,
        TGT_SOVR = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        MSK_FULL = 2'd0,
        MSK_UOVR = 2'd1,
        MSK_SOVR = 2'd2
    } msel_e;

    typedef struct packed {
        logic    legal;
        target_e tgt;
        msel_e   msel;
    } decision_t;

    // User state wins over the hypervisor bit.
    function automatic ctx_e ctx_of(input logic user, input logic hyp);
        if (user)     return CTX_USER;
        else if (hyp) return CTX_HYP;
        else          return CTX_SUP;
    endfunction

    // Mask that governs an authority write in a given context.
    function automatic msel_e auth_mask_for(input ctx_e c);
        case (c)
            CTX_USER: return MSK_UOVR;
            CTX_SUP:  return MSK_SOVR;
            default:  return MSK_FULL;
        endcase
    endfunction

endpackage

// File: rtl/auth_access_decode.sv
module auth_access_decode
    import auth_mask_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          priv_user,
    input  logic          priv_hyp,
    output decision_t     dec
);
    ctx_e ctx;

    always_comb begin
        ctx       = ctx_of(priv_user, priv_hyp);
        dec.legal = 1'b0;
        dec.tgt   = TGT_NONE;
        dec.msel  = MSK_FULL;
        if (addr == AW'(NUM_AUTH_USR)) begin
            dec.legal = 1'b1;
            dec.tgt   = TGT_AUTH;
            dec.msel  = auth_mask_for(ctx);
        end else if (addr == AW'(NUM_AUTH_PRV)) begin
            dec.legal = (ctx != CTX_USER);
            dec.tgt   = TGT_AUTH;
            dec.msel  = auth_mask_for(ctx);
        end else if (addr == AW'(NUM_UOVR)) begin
            dec.legal = (ctx != CTX_USER);
            dec.tgt   = TGT_UOVR;
            dec.msel  = (ctx == CTX_HYP) ? MSK_FULL : MSK_SOVR;
        end else if (addr == AW'(NUM_SOVR)) begin
            dec.legal = (ctx == CTX_HYP);
            dec.tgt   = TGT_SOVR;
            dec.msel  = MSK_FULL;
        end
    end

endmodule

// File: rtl/auth_bit_insert.sv
module auth_bit_insert #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] mask,
    output logic [W-1:0] merged
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign merged[i] = mask[i] ? new_val[i] : old_val[i];
    end
endmodule

// File: rtl/auth_reg_bank.sv
module auth_reg_bank
    import auth_mask_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  target_e      tgt,
    input  logic [W-1:0] wval,
    output logic [W-1:0] auth_q,
    output logic [W-1:0] uovr_q,
    output logic [W-1:0] sovr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            auth_q <= '0;
            uovr_q <= '0;
            sovr_q <= '0;
        end else if (we) begin
            case (tgt)
                TGT_AUTH: auth_q <= wval;
                TGT_UOVR: uovr_q <= wval;
                TGT_SOVR: sovr_q <= wval;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/auth_mask_block.sv
module auth_mask_block
    import auth_mask_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    input  logic          priv_user,
    input  logic          priv_hyp,
    output logic [DW-1:0] rdata,
    output logic          access_err
);
    decision_t     dec;
    logic [DW-1:0] auth_q, uovr_q, sovr_q;
    logic [DW-1:0] sel_mask, sel_old, merged, cur_val;
    logic          wr_go;

    auth_access_decode #(.AW(AW)) u_dec (
        .addr      (addr),
        .priv_user (priv_user),
        .priv_hyp  (priv_hyp),
        .dec       (dec)
    );

    always_comb begin
        case (dec.msel)
            MSK_UOVR: sel_mask = uovr_q;
            MSK_SOVR: sel_mask = sovr_q;
            default:  sel_mask = '1;
        endcase
        case (dec.tgt)
            TGT_AUTH: cur_val = auth_q;
            TGT_UOVR: cur_val = uovr_q;
            TGT_SOVR: cur_val = sovr_q;
            default:  cur_val = '0;
        endcase
        sel_old = cur_val;
    end

    auth_bit_insert #(.W(DW)) u_ins (
        .old_val (sel_old),
        .new_val (wdata),
        .mask    (sel_mask),
        .merged  (merged)
    );

    assign wr_go      = wr_en && dec.legal;
    assign access_err = (wr_en || rd_en) && !dec.legal;
    assign rdata      = (rd_en && dec.legal) ? cur_val : '0;

    auth_reg_bank #(.W(DW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_go),
        .tgt    (dec.tgt),
        .wval   (merged),
        .auth_q (auth_q),
        .uovr_q (uovr_q),
        .sovr_q (sovr_q)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (auth_q == '0 && uovr_q == '0 && sovr_q == '0));

    // R2
    user_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && priv_user && addr == AW'(NUM_AUTH_USR)) |=>
        auth_q == (($past(auth_q) & ~$past(uovr_q)) | ($past(wdata) & $past(uovr_q))));

    // R4
    hyp_full_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && priv_hyp && !priv_user &&
         (addr == AW'(NUM_AUTH_USR) || addr == AW'(NUM_AUTH_PRV))) |=>
        auth_q == $past(wdata));

    // R7
    user_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_user && (wr_en || rd_en) &&
         (addr == AW'(NUM_AUTH_PRV) || addr == AW'(NUM_UOVR))) |-> access_err);

    // R8
    sovr_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && priv_hyp && !priv_user && addr == AW'(NUM_SOVR)) |=>
        $stable(sovr_q));

    // R7
    err_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        access_err |-> rdata == '0);

endmodule

// File: tb/tb_auth_mask_block.sv
module tb_auth_mask_block;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [63:0] wdata = '0;
    logic        priv_user = 1'b0, priv_hyp = 1'b0;
    logic [63:0] rdata;
    logic        access_err;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // reference state
    logic [63:0] m_auth = '0, m_uovr = '0, m_sovr = '0;

    always #(CLK_P/2) clk = ~clk;

    auth_mask_block dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .priv_user(priv_user), .priv_hyp(priv_hyp),
        .rdata(rdata), .access_err(access_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_for(input logic u, input logic h,
                                      input logic [9:0] a, input logic w, input bit ok);
        if (u && h) return "R11";
        if (!ok) begin
            if (a == 10'd41) return "R8";
            if (a == 10'd13 || a == 10'd29 || a == 10'd40) return "R7";
            return "R9";
        end
        if (!w) return (a == 10'd29) ? "R6" : "R10";
        if (a == 10'd40) return "R5";
        if (a == 10'd41) return "R8";
        if (u) return "R2";
        if (h) return "R4";
        return "R3";
    endfunction

    // One access cycle: drive at negedge, check outputs, update model at posedge.
    task automatic access(input logic u, input logic h, input logic [9:0] a,
                          input logic w, input logic r, input logic [63:0] d);
        bit user_ctx, hyp_ctx, ok;
        logic [63:0] cur, e_rd, nxt_auth, nxt_uovr, nxt_sovr;
        string tg;
        @(negedge clk);
        priv_user = u; priv_hyp = h; addr = a; wr_en = w; rd_en = r; wdata = d;
        user_ctx = u;
        hyp_ctx  = !u && h;
        cur = '0;
        ok  = 0;
        if (a == 10'd13)      begin ok = 1;         cur = m_auth; end
        else if (a == 10'd29) begin ok = !user_ctx; cur = m_auth; end
        else if (a == 10'd40) begin ok = !user_ctx; cur = m_uovr; end
        else if (a == 10'd41) begin ok = hyp_ctx;   cur = m_sovr; end
        nxt_auth = m_auth; nxt_uovr = m_uovr; nxt_sovr = m_sovr;
        if (w && ok) begin
            if (a == 10'd13 || a == 10'd29) begin
                if (user_ctx)     nxt_auth = (m_auth & ~m_uovr) | (d & m_uovr);
                else if (hyp_ctx) nxt_auth = d;
                else              nxt_auth = (m_auth & ~m_sovr) | (d & m_sovr);
            end else if (a == 10'd40) begin
                nxt_uovr = hyp_ctx ? d : ((m_uovr & ~m_sovr) | (d & m_sovr));
            end else begin
                nxt_sovr = d;
            end
        end
        e_rd = (r && ok) ? cur : '0;
        tg = tag_for(u, h, a, w, ok);
        #1;
        chk(tg, "access_err", {63'd0, access_err}, {63'd0, ((w || r) && !ok)});
        chk(tg, "rdata", rdata, e_rd);
        @(posedge clk);
        m_auth = nxt_auth; m_uovr = nxt_uovr; m_sovr = nxt_sovr;
    endtask

    task automatic readback();
        access(0, 1, 10'd13, 0, 1, '0);
        access(0, 1, 10'd29, 0, 1, '0);
        access(0, 1, 10'd40, 0, 1, '0);
        access(0, 1, 10'd41, 0, 1, '0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: all registers zero after reset
        readback();
        access(1, 0, 10'd13, 0, 1, '0);

        // R8, R5: hypervisor loads two distinct masks
        access(0, 1, 10'd41, 1, 0, 64'hF0F0_F0F0_00FF_00FF);
        access(0, 1, 10'd40, 1, 0, 64'hFFFF_0000_FFFF_0000);
        readback();
        // R5: supervisor write to user mask inserted under supervisor mask
        access(0, 0, 10'd40, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        access(0, 0, 10'd40, 1, 0, 64'h0000_0000_0000_0000);
        readback();
        // R2: user writes through the open alias
        access(1, 0, 10'd13, 1, 0, '1);
        access(1, 0, 10'd13, 0, 1, '0);
        access(1, 0, 10'd13, 1, 0, 64'h1234_5678_9ABC_DEF0);
        readback();
        // R3: supervisor writes through both aliases
        access(0, 0, 10'd29, 1, 0, '1);
        access(0, 0, 10'd13, 1, 0, '0);
        readback();
        // R4: hypervisor full store, R6 alias equality
        access(0, 1, 10'd13, 1, 0, 64'hDEAD_BEEF_0BAD_F00D);
        access(0, 1, 10'd29, 0, 1, '0);
        access(0, 1, 10'd29, 1, 0, 64'h0123_4567_89AB_CDEF);
        access(1, 0, 10'd13, 0, 1, '0);
        // R7: user blocked from privileged alias and user mask
        access(1, 0, 10'd29, 1, 0, '1);
        access(1, 0, 10'd29, 0, 1, '0);
        access(1, 0, 10'd40, 1, 0, '1);
        access(1, 0, 10'd40, 0, 1, '0);
        readback();
        // R8: supervisor mask closed outside hypervisor
        access(0, 0, 10'd41, 1, 0, '0);
        access(0, 0, 10'd41, 0, 1, '0);
        access(1, 0, 10'd41, 1, 0, '0);
        readback();
        // R9: unmapped numbers
        access(0, 1, 10'd7, 1, 0, '1);
        access(0, 1, 10'd1023, 0, 1, '0);
        readback();
        // R11: both bits set act as user
        access(1, 1, 10'd13, 1, 0, '1);
        access(1, 1, 10'd29, 0, 1, '0);
        access(1, 1, 10'd41, 1, 0, '1);
        readback();
        // R10: no access gives no error and zero data
        access(0, 1, 10'd13, 0, 0, '1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [9:0] a;
            case ($urandom_range(0, 5))
                0: a = 10'd13;
                1: a = 10'd29;
                2: a = 10'd40;
                3: a = 10'd41;
                4: a = 10'd13;
                default: a = 10'($urandom_range(0, 1023));
            endcase
            access(1'($urandom), 1'($urandom), a, 1'($urandom), 1'($urandom),
                   {$urandom, $urandom});
        end
        readback();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule